// File: doc/BRIEF.md
# Fixed-Point Texture Span Copier

The block fills one horizontal run of framebuffer words from a texture held in memory, for surfaces whose texture coordinate advances linearly along the run. Software loads a texture base address, a destination start address, a 32-bit fixed-point start coordinate, a per-pixel coordinate increment and a pixel count, then pulses `start`. For every pixel the upper half of the coordinate accumulator selects a 32-bit texel. That texel is fetched through a request/ready read port, whose data returns in order with a valid strobe. It is then written to the next consecutive framebuffer word through a request/ready write port.

Work proceeds in groups of up to four pixels. Four texel addresses are formed in one cycle. Their reads are issued back to back, and only once every texel of the group has returned are the group's writes sent out. Address arithmetic therefore never sits between a read response and the next request. The copy does not depend on colour depth: any pixel format that fits in a 32-bit word passes through unchanged.

The controller has four states. IDLE waits for a start pulse. INDEX forms the group's addresses. READ issues the reads and collects the texels. WRITE stores the group. The transitions are: IDLE->INDEX on a start with a nonzero count; IDLE->IDLE with a done pulse on a start with a zero count; INDEX->READ always; READ->WRITE when the last texel of the group arrives; WRITE->INDEX when the group ends and pixels remain; WRITE->IDLE with a done pulse when the last pixel is accepted.

Top module: `span_copier`

## Requirements
- R1: Pixel i reads address `tex_base + 4 * (acc_i >> 16)`, where `acc_0 = coord_init` and `acc` is 32 bits wide.
- R2: `acc_(i+1) = acc_i + coord_step` modulo 2^32, so the accumulator wraps and only its upper 16 bits select the texel.
- R3: Write i goes to `dst_base + 4*i` and carries the data returned for read i.
- R4: Pixels are handled in groups of four, counted from pixel 0. All reads of a group are accepted before any write of that group. Every write of a group is accepted before any read of the next group. A read request and a write request are never raised in the same cycle.
- R5: A start with `pix_count` equal to 0 raises `done` in the cycle after the start edge, with no read or write request and without `busy`.
- R6: A count that is not a multiple of four ends with a partial group, and exactly `pix_count` reads and `pix_count` writes are made.
- R7: A request that is not accepted (ready low) stays raised with an unchanged address and data. A missing `rd_valid` stalls the copy. Pixels are neither lost nor reordered.
- R8: `done` is a one-cycle pulse in the cycle after the last write is accepted, and `busy` is low while `done` is high. `busy` is high from the cycle after a start with a nonzero count until then. A start and any configuration change during a run have no effect.
- R9: While `busy` is low, neither `rd_req` nor `wr_req` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a span (sampled while idle) |
| tex_base | input | AW | Texture byte base address |
| dst_base | input | AW | First framebuffer byte address |
| coord_init | input | 32 | Start coordinate, 16.16 fixed point |
| coord_step | input | 32 | Per-pixel coordinate increment |
| pix_count | input | CW | Number of pixels in the span |
| busy | output | 1 | Span in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_req | output | 1 | Texel read request |
| rd_addr | output | AW | Texel read byte address |
| rd_ready | input | 1 | Read request accepted |
| rd_valid | input | 1 | Read data returned (in order) |
| rd_data | input | DW | Texel data |
| wr_req | output | 1 | Framebuffer write request |
| wr_addr | output | AW | Framebuffer byte address |
| wr_data | output | DW | Pixel data |
| wr_ready | input | 1 | Write request accepted |

## Verification
The assertions check the following on every cycle: requests held stable under back-pressure, reads and writes never requested together, silence while idle, and the shape of the done pulse against busy. Only the bench scenarios can show the numeric results. These are the exact texel addresses from the fixed-point accumulator including its wrap, the consecutive destination addresses and copied data, the group ordering of reads against writes, the partial final group, and the zero-count case. The bench scenarios also show that a start or configuration change in mid-run leaves the output sequence untouched.

// File: rtl/span_pkg.sv
package span_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INDEX = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } span_state_t;
endpackage

// File: rtl/span_idx_gen.sv
module span_idx_gen #(
    parameter int AW  = 32,
    parameter int GRP = 4
) (
    input  logic [AW-1:0] base,
    input  logic [31:0]   acc,
    input  logic [31:0]   step,
    output logic [AW-1:0] addr [GRP]
);
    for (genvar k = 0; k < GRP; k++) begin : g_lane
        logic [31:0] lane_acc;
        assign lane_acc = acc + step * 32'(k);
        assign addr[k]  = base + AW'({lane_acc[31:16], 2'b00});
    end
endmodule

// File: rtl/span_texbuf.sv
module span_texbuf #(
    parameter int GRP = 4,
    parameter int DW  = 32,
    localparam int IW = (GRP > 1) ? $clog2(GRP) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [GRP];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/span_copier.sv
module span_copier
    import span_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 16,
    parameter int GRP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] tex_base,
    input  logic [AW-1:0] dst_base,
    input  logic [31:0]   coord_init,
    input  logic [31:0]   coord_step,
    input  logic [CW-1:0] pix_count,
    output logic          busy,
    output logic          done,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ready,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ready
);
    localparam int IW = (GRP > 1) ? $clog2(GRP) : 1;
    localparam int GW = $clog2(GRP + 1);
    localparam int LG = $clog2(GRP);

    span_state_t state_q, state_d;

    logic [AW-1:0] base_q, dst_q;
    logic [31:0]   acc_q, step_q;
    logic [CW-1:0] rem_q;
    logic [GW-1:0] grp_q, issued_q, rcvd_q, wcnt_q;
    logic [AW-1:0] addr_q [GRP];
    logic [AW-1:0] addr_d [GRP];
    logic          done_q;

    logic rd_fire, wr_fire, last_rcv, grp_end, span_end;

    span_idx_gen #(.AW(AW), .GRP(GRP)) i_idx (
        .base (base_q),
        .acc  (acc_q),
        .step (step_q),
        .addr (addr_d)
    );

    span_texbuf #(.GRP(GRP), .DW(DW)) i_buf (
        .clk   (clk),
        .we    (state_q == ST_READ && rd_valid),
        .widx  (rcvd_q[IW-1:0]),
        .wdata (rd_data),
        .ridx  (wcnt_q[IW-1:0]),
        .rdata (wr_data)
    );

    assign rd_fire  = rd_req && rd_ready;
    assign wr_fire  = wr_req && wr_ready;
    assign last_rcv = (state_q == ST_READ) && rd_valid && (rcvd_q == grp_q - 1'b1);
    assign grp_end  = wr_fire && (wcnt_q == grp_q - 1'b1);
    assign span_end = grp_end && (rem_q == CW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && pix_count != '0) state_d = ST_INDEX;
            ST_INDEX: state_d = ST_READ;
            ST_READ:  if (last_rcv) state_d = ST_WRITE;
            ST_WRITE: if (span_end) state_d = ST_IDLE;
                      else if (grp_end) state_d = ST_INDEX;
        endcase
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = done_q;
        rd_req  = 1'b0;
        rd_addr = addr_q[issued_q[IW-1:0]];
        wr_req  = 1'b0;
        wr_addr = dst_q;
        unique case (state_q)
            ST_IDLE:  ;
            ST_INDEX: ;
            ST_READ:  rd_req = (issued_q < grp_q);
            ST_WRITE: wr_req = 1'b1;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            base_q   <= '0;
            dst_q    <= '0;
            acc_q    <= '0;
            step_q   <= '0;
            rem_q    <= '0;
            grp_q    <= '0;
            issued_q <= '0;
            rcvd_q   <= '0;
            wcnt_q   <= '0;
            for (int k = 0; k < GRP; k++) addr_q[k] <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    base_q <= tex_base;
                    dst_q  <= dst_base;
                    acc_q  <= coord_init;
                    step_q <= coord_step;
                    rem_q  <= pix_count;
                    done_q <= (pix_count == '0);
                end
                ST_INDEX: begin
                    for (int k = 0; k < GRP; k++) addr_q[k] <= addr_d[k];
                    acc_q    <= acc_q + (step_q << LG);
                    grp_q    <= (rem_q >= CW'(GRP)) ? GW'(GRP) : GW'(rem_q);
                    issued_q <= '0;
                    rcvd_q   <= '0;
                    wcnt_q   <= '0;
                end
                ST_READ: begin
                    if (rd_fire)  issued_q <= issued_q + 1'b1;
                    if (rd_valid) rcvd_q   <= rcvd_q + 1'b1;
                end
                ST_WRITE: if (wr_fire) begin
                    dst_q  <= dst_q + AW'(4);
                    wcnt_q <= wcnt_q + 1'b1;
                    rem_q  <= rem_q - 1'b1;
                    done_q <= span_end;
                end
            endcase
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ready |=> rd_req && $stable(rd_addr)); // R7
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ready |=> wr_req && $stable(wr_addr) && $stable(wr_data)); // R7
    AST_NO_MIXED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req && !wr_req); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_WRITE_AFTER_GRP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> $past(state_q == ST_READ)); // R4
endmodule

// File: tb/test_span_copier.sv
module test_span_copier;
    localparam int AW = 32, DW = 32, CW = 16;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] tex_base = '0, dst_base = '0;
    logic [31:0]   coord_init = '0, coord_step = '0;
    logic [CW-1:0] pix_count = '0;
    logic busy, done, rd_req, wr_req;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] wr_data, rd_data = '0;
    logic rd_ready = 1'b0, rd_valid = 1'b0, wr_ready = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    span_copier i_span_copier (.*);

    int total = 0, bad = 0;
    int cyc = 0;
    bit stall = 0;

    logic [AW-1:0] rd_log [64];
    logic [AW-1:0] wa_log [64];
    logic [DW-1:0] wd_log [64];
    int rd_pre [64];
    int wr_pre [64];
    logic [AW-1:0] q [64];
    int rd_cnt = 0, wr_cnt = 0, qh = 0, qt = 0;

    function automatic logic [DW-1:0] texel(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h1111};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_req && rd_ready) begin
            rd_log[rd_cnt % 64] = rd_addr;
            wr_pre[rd_cnt % 64] = wr_cnt;
            q[qt % 64] = rd_addr;
            qt = qt + 1;
            rd_cnt = rd_cnt + 1;
        end
        if (rd_valid) qh = qh + 1;
        if (wr_req && wr_ready) begin
            wa_log[wr_cnt % 64] = wr_addr;
            wd_log[wr_cnt % 64] = wr_data;
            rd_pre[wr_cnt % 64] = rd_cnt;
            wr_cnt = wr_cnt + 1;
        end
    end

    always @(negedge clk) begin
        rd_ready <= !stall || (cyc % 3 == 0);
        wr_ready <= !stall || (cyc % 4 == 1);
        if (qh != qt && (!stall || cyc % 2 == 0)) begin
            rd_valid <= 1'b1;
            rd_data  <= texel(q[qh % 64]);
        end else begin
            rd_valid <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // runs one span and checks every address, data word and ordering
    task automatic run_span(input string tag, input int n, input logic [31:0] base,
                            input logic [31:0] dst, input logic [31:0] init,
                            input logic [31:0] stp, input bit stl, input bit poke);
        logic [31:0] acc;
        int waited;
        bit seen;
        @(negedge clk);
        stall = stl;
        rd_cnt = 0; wr_cnt = 0; qh = 0; qt = 0;
        tex_base = base; dst_base = dst; coord_init = init;
        coord_step = stp; pix_count = CW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1, "R5", "done after zero start", 64'(done), 1);
            chk(busy == 1'b0, "R5", "busy on zero count", 64'(busy), 0);
        end else begin
            chk(busy == 1'b1, "R8", "busy after start", 64'(busy), 1);
        end
        waited = 0;
        seen = done;
        while (!seen && waited < 5000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 5) begin
                start = 1'b1; pix_count = CW'(3); tex_base = 32'hDEAD0000;
                dst_base = 32'h0; coord_step = 32'h0;
            end
            if (poke && waited == 6) start = 1'b0;
            seen = done;
        end
        chk(seen, "R8", "done seen (watchdog)", 64'(seen), 1);
        chk(busy == 1'b0, "R8", "busy low with done", 64'(busy), 0);
        chk(rd_cnt == n, "R6", "read count", rd_cnt, n);
        chk(wr_cnt == n, "R6", "write count", wr_cnt, n);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done one cycle", 64'(done), 0);
        chk(!rd_req && !wr_req, "R9", "quiet after done", 64'({rd_req, wr_req}), 0);
        acc = init;
        for (int i = 0; i < n && i < rd_cnt && i < wr_cnt; i++) begin
            logic [31:0] ea;
            ea = base + {14'd0, acc[31:16], 2'b00};
            chk(rd_log[i] == ea, {tag, " R1 R2"}, $sformatf("read addr %0d", i), rd_log[i], ea);
            chk(wa_log[i] == dst + 32'(4 * i), "R3", $sformatf("write addr %0d", i),
                wa_log[i], dst + 32'(4 * i));
            chk(wd_log[i] == texel(ea), "R3", $sformatf("write data %0d", i), wd_log[i], texel(ea));
            chk(rd_pre[i] == ((i / 4 + 1) * 4 < n ? (i / 4 + 1) * 4 : n), "R4",
                $sformatf("reads before write %0d", i), rd_pre[i],
                ((i / 4 + 1) * 4 < n ? (i / 4 + 1) * 4 : n));
            chk(wr_pre[i] == (i / 4) * 4, "R4", $sformatf("writes before read %0d", i),
                wr_pre[i], (i / 4) * 4);
            acc = acc + stp;
        end
        stall = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0, "R9", "reset busy", 64'(busy), 0);
        chk(done == 1'b0, "R8", "reset done", 64'(done), 0);
        chk(!rd_req && !wr_req, "R9", "reset requests", 64'({rd_req, wr_req}), 0);
    endtask

    task automatic t_basic();      run_span("basic",   8, 32'h0001_0000, 32'h0008_0000, 32'h0,          32'h0001_0000, 0, 0); endtask
    task automatic t_fraction();   run_span("frac",    7, 32'h0002_0000, 32'h0009_0000, 32'h0000_C000,  32'h0000_8000, 0, 0); endtask
    task automatic t_wrap();       run_span("wrap",    5, 32'h0003_0000, 32'h000A_0000, 32'hFFFF_0000,  32'h0001_0000, 0, 0); endtask
    task automatic t_zero();       run_span("zero",    0, 32'h0004_0000, 32'h000B_0000, 32'h0,          32'h0001_0000, 0, 0);
        chk(rd_cnt == 0 && wr_cnt == 0, "R5", "no traffic on zero", rd_cnt + wr_cnt, 0); endtask
    task automatic t_stall();      run_span("stall R7", 10, 32'h0005_0000, 32'h000C_0000, 32'h0012_3456, 32'h0002_4000, 1, 1); endtask
    task automatic t_single();     run_span("single",  1, 32'h0006_0000, 32'h000D_0000, 32'h0007_0000,  32'hFFFF_0000, 0, 0); endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_basic();
                t_fraction();
                t_wrap();
                t_zero();
                t_stall();
                t_single();
            end
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "R8", "global watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule